// File: doc/BRIEF.md
# Packed Rounding Multiply-High Unit

This block is a registered SIMD arithmetic unit for a 64-bit datapath. Each cycle it can accept a pair of 64-bit operands, A and B, and an opcode. It returns one of three kinds of result. The first is the upper half of lane products, over four 16-bit lanes or two 32-bit lanes, in signed or unsigned form, with or without round-to-nearest. The second is the lower 32 bits of two 32x32 lane products. The third is a packing add: each signed halfword of A is added to a zero-extended byte of B, and the result is clamped to unsigned bytes placed in one half of the output.

The rounding bias is half the weight of the bits that are dropped. It is added to the full product before the shift. The sums are kept wide enough that the bias cannot carry out of the datapath. Results are registered and show up, together with a valid flag, one clock after the input is presented.

Top module: `pmulhi_unit`

## Requirements
- R1: A synchronous active-high reset clears the result register to zero and drops the result valid flag. Both stay cleared on the clock edge after reset is sampled, even if input valid is high.
- R2: The result valid flag equals the input valid sampled on the previous clock edge. The result register loads only on a cycle when input valid is high; otherwise it holds its value.
- R3: Opcode 0 (signed) and opcode 1 (unsigned) give, for each of four 16-bit lanes (lane i in bits 16i+15:16i), bits 15:0 of (a*b + 2^15) shifted right by 16. Signed mode uses sign extension and an arithmetic shift; unsigned mode uses zero extension and a logical shift.
- R4: Opcode 2 (signed) and opcode 3 (unsigned) give, for each of two 32-bit lanes (lane j in bits 32j+31:32j), bits 63:32 of the full 64-bit product.
- R5: Opcode 4 (signed) and opcode 5 (unsigned) give, for each 32-bit lane, bits 31:0 of (a*b + 2^31) shifted right by 32.
- R6: Opcode 6 gives, for each 32-bit lane, the low 32 bits of the lane product.
- R7: Opcode 7 adds each signed 16-bit lane i of A to the zero-extended byte i of B (bits 8i+7:8i, i = 0..3). The sum is saturated to the signed 16-bit range and then clamped to 0..255. Byte i of the result goes in bits 8i+7:8i, and bits 63:32 are zero.
- R8: Opcode 8 works as opcode 7 but takes byte i+4 of B (bits 32+8i+7:32+8i). The result byte goes in bits 32+8i+7:32+8i, and bits 31:0 are zero.
- R9: Opcodes 9 to 15 load an all-zero result, and the valid flag still follows R2.
- R10: At the extreme operands (all ones unsigned, -32768 squared signed), the rounding bias never overflows. An all-ones unsigned 16-bit lane pair gives 0xFFFE, and an all-ones unsigned 32-bit lane pair with rounding gives 0xFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 1 | Operands and opcode are valid this cycle |
| op_i | input | 4 | Operation select (encoding in R3 to R9) |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| res_o | output | 64 | Registered result |
| res_vld_o | output | 1 | Result valid, one cycle after in_vld_i |

## Verification
Every result passes through exactly one register, so each output is due on the first rising edge after the operands are driven. The bench drives inputs on the falling edge and samples res_o and res_vld_o on the next falling edge, half a period after that capture edge. The valid flag is also sampled once before that edge to show it has not yet risen. Hold and reset cases are sampled one edge after the idle or reset cycle, which is when a wrong load or a missed clear would become visible.

// File: rtl/pmh_pkg.sv
package pmh_pkg;
  typedef enum logic [3:0] {
    OP_H16R_S  = 4'd0,
    OP_H16R_U  = 4'd1,
    OP_H32_S   = 4'd2,
    OP_H32_U   = 4'd3,
    OP_H32R_S  = 4'd4,
    OP_H32R_U  = 4'd5,
    OP_LO32    = 4'd6,
    OP_PKADD_L = 4'd7,
    OP_PKADD_H = 4'd8
  } pmh_op_e;

  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/pmh_lane16.sv
module pmh_lane16 #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sgn_i,
  output logic [W-1:0] hi_o
);
  localparam int unsigned PW = 2*W + 2;
  localparam logic signed [PW-1:0] BIAS = PW'(1) << (W-1);

  logic signed [W:0]    ax, bx;
  logic signed [PW-1:0] prod, sum;

  // one extra bit selects sign or zero extension, so both modes share a multiplier
  assign ax   = {sgn_i & a_i[W-1], a_i};
  assign bx   = {sgn_i & b_i[W-1], b_i};
  assign prod = PW'(ax) * PW'(bx);
  assign sum  = prod + BIAS;
  assign hi_o = W'(sum >>> W);
endmodule

// File: rtl/pmh_lane32.sv
module pmh_lane32 #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sgn_i,
  input  logic         rnd_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  localparam int unsigned PW = 2*W + 2;
  localparam logic signed [PW-1:0] BIAS = PW'(1) << (W-1);

  logic signed [W:0]    ax, bx;
  logic signed [PW-1:0] prod, sum;

  assign ax   = {sgn_i & a_i[W-1], a_i};
  assign bx   = {sgn_i & b_i[W-1], b_i};
  assign prod = PW'(ax) * PW'(bx);
  assign sum  = prod + (rnd_i ? BIAS : '0);
  assign hi_o = W'(sum >>> W);
  assign lo_o = W'(prod);
endmodule

// File: rtl/pmh_packlane.sv
module pmh_packlane #(
  parameter int unsigned W  = 16,
  parameter int unsigned BW = 8
) (
  input  logic [W-1:0]  a_i,
  input  logic [BW-1:0] b_i,
  output logic [BW-1:0] q_o
);
  localparam logic signed [W:0] SMAX = (W+1)'((2**(W-1)) - 1);
  localparam logic signed [W:0] SMIN = -(W+1)'(2**(W-1));
  localparam logic signed [W-1:0] UMAX = W'((2**BW) - 1);

  logic signed [W:0]   s;
  logic signed [W-1:0] s16;

  assign s = {a_i[W-1], a_i} + {{(W+1-BW){1'b0}}, b_i};

  always_comb begin
    if (s > SMAX)      s16 = SMAX[W-1:0];
    else if (s < SMIN) s16 = SMIN[W-1:0];
    else               s16 = s[W-1:0];
  end

  always_comb begin
    if (s16 < 0)         q_o = '0;
    else if (s16 > UMAX) q_o = '1;
    else                 q_o = BW'(s16);
  end
endmodule

// File: rtl/pmulhi_unit.sv
module pmulhi_unit
  import pmh_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_vld_o
);
  localparam int unsigned N16  = DATA_W / HALF_W;
  localparam int unsigned N32  = DATA_W / WORD_W;
  localparam int unsigned HALF = DATA_W / 2;
  localparam int unsigned NPK  = HALF / BYTE_W;

  pmh_op_e op;
  logic    sgn16, sgn32, rnd32, pk_hi;
  logic [DATA_W-1:0] h16, h32, l32, nxt;
  logic [HALF-1:0]   pk;

  assign op    = pmh_op_e'(op_i);
  assign sgn16 = (op == OP_H16R_S);
  assign sgn32 = (op == OP_H32_S) || (op == OP_H32R_S);
  assign rnd32 = (op == OP_H32R_S) || (op == OP_H32R_U);
  assign pk_hi = (op == OP_PKADD_H);

  for (genvar g = 0; g < N16; g++) begin : g_h16
    pmh_lane16 #(.W(HALF_W)) i_lane (
      .a_i   (a_i[g*HALF_W +: HALF_W]),
      .b_i   (b_i[g*HALF_W +: HALF_W]),
      .sgn_i (sgn16),
      .hi_o  (h16[g*HALF_W +: HALF_W])
    );
  end

  for (genvar g = 0; g < N32; g++) begin : g_w32
    pmh_lane32 #(.W(WORD_W)) i_lane (
      .a_i   (a_i[g*WORD_W +: WORD_W]),
      .b_i   (b_i[g*WORD_W +: WORD_W]),
      .sgn_i (sgn32),
      .rnd_i (rnd32),
      .hi_o  (h32[g*WORD_W +: WORD_W]),
      .lo_o  (l32[g*WORD_W +: WORD_W])
    );
  end

  for (genvar g = 0; g < NPK; g++) begin : g_pk
    logic [BYTE_W-1:0] bsel;
    assign bsel = pk_hi ? b_i[HALF + g*BYTE_W +: BYTE_W] : b_i[g*BYTE_W +: BYTE_W];
    pmh_packlane #(.W(HALF_W), .BW(BYTE_W)) i_lane (
      .a_i (a_i[g*HALF_W +: HALF_W]),
      .b_i (bsel),
      .q_o (pk[g*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    case (op)
      OP_H16R_S, OP_H16R_U:             nxt = h16;
      OP_H32_S, OP_H32_U,
      OP_H32R_S, OP_H32R_U:             nxt = h32;
      OP_LO32:                          nxt = l32;
      OP_PKADD_L:                       nxt = {{HALF{1'b0}}, pk};
      OP_PKADD_H:                       nxt = {pk, {HALF{1'b0}}};
      default:                          nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= in_vld_i;
      if (in_vld_i) res_o <= nxt;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !res_vld_o));

  p_vld_rise_r2: assert property (@(posedge clk) disable iff (rst)
    in_vld_i |=> res_vld_o);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_vld_i |=> (!res_vld_o && $stable(res_o)));

  p_pack_lo_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_vld_i && op_i == 4'd7) |=> (res_o[DATA_W-1:HALF] == '0));

  p_pack_hi_lower_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (in_vld_i && op_i == 4'd8) |=> (res_o[HALF-1:0] == '0));

  p_bad_op_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (in_vld_i && op_i > 4'd8) |=> (res_o == '0));
endmodule

// File: tb/test_pmulhi_unit.sv
module test_pmulhi_unit;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic [63:0] res;
  logic        res_vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // {opcode, A, B, expected}
  localparam logic [195:0] VECS [NV] = '{
    {4'h0, 64'hFFFF_4000_8000_0001, 64'h0001_4000_8000_0001, 64'h0000_1000_4000_0000},
    {4'h1, 64'hFFFF_4000_8000_0001, 64'h0001_4000_8000_0001, 64'h0001_1000_4000_0000},
    {4'h0, 64'h0003_7FFF_8000_FFFF, 64'hC000_7FFF_7FFF_8000, 64'hFFFF_3FFF_C001_0001},
    {4'h2, 64'h8000_0000_FFFF_FFFF, 64'h8000_0000_0000_0002, 64'h4000_0000_FFFF_FFFF},
    {4'h3, 64'h8000_0000_FFFF_FFFF, 64'h8000_0000_0000_0002, 64'h4000_0000_0000_0001},
    {4'h4, 64'h0000_0003_8000_0000, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_0000_0000},
    {4'h5, 64'h8000_0000_FFFF_FFFF, 64'h0000_0001_FFFF_FFFF, 64'h0000_0001_FFFF_FFFE},
    {4'h6, 64'hFFFF_FFFF_0001_0001, 64'h0000_0003_0001_0001, 64'hFFFF_FFFD_0002_0001},
    {4'h7, 64'h7FFF_00F0_FFF0_0005, 64'h4433_2211_FF20_050A, 64'h0000_0000_FFFF_000F},
    {4'h8, 64'h7FFF_00F0_FFF0_0005, 64'h4433_2211_FF20_050A, 64'hFFFF_1216_0000_0000},
    {4'h7, 64'h8000_8000_8000_8000, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_0000},
    {4'hB, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000}
  };

  pmulhi_unit i_pmulhi_unit (
    .clk       (clk),
    .rst       (rst),
    .in_vld_i  (in_vld),
    .op_i      (op),
    .a_i       (a),
    .b_i       (b),
    .res_o     (res),
    .res_vld_o (res_vld)
  );

  always #5 clk = ~clk;

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'h0, 4'h1:             return "R3";
      4'h2, 4'h3:             return "R4";
      4'h4, 4'h5:             return "R5";
      4'h6:                   return "R6";
      4'h7:                   return "R7";
      4'h8:                   return "R8";
      default:                return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y);
    @(negedge clk);
    in_vld = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 result", res, 64'h0);
    check("R1 valid", {63'h0, res_vld}, 64'h0);
    rst = 1'b0;

    // table walk: each result due one edge after the operands are driven
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][195:192], VECS[i][191:128], VECS[i][127:64]);
      check(tag_of(VECS[i][195:192]), res, VECS[i][63:0]);
      check("R2 valid", {63'h0, res_vld}, 64'h1);
    end

    // R10: extremes of the rounding bias
    apply(4'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R10 u16", res, 64'hFFFE_FFFE_FFFE_FFFE);
    apply(4'h5, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R10 u32", res, 64'hFFFF_FFFE_FFFF_FFFE);
    apply(4'h0, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
    check("R10 s16", res, 64'h4000_4000_4000_4000);

    // R2: valid low before the capture edge, high after, result held while idle
    @(negedge clk);
    in_vld = 1'b1; op = 4'h6; a = 64'h0000_0002_0000_0003; b = 64'h0000_0005_0000_0007;
    #1;
    check("R2 valid before edge", {63'h0, res_vld}, 64'h0);
    @(negedge clk);
    check("R6 small", res, 64'h0000_000A_0000_0015);
    in_vld = 1'b0; op = 4'h1; a = '1; b = '1;
    @(negedge clk);
    check("R2 hold result", res, 64'h0000_000A_0000_0015);
    check("R2 valid drop", {63'h0, res_vld}, 64'h0);

    // R1: reset with a valid input present still clears
    in_vld = 1'b1; op = 4'h6; rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run result", res, 64'h0);
    check("R1 mid-run valid", {63'h0, res_vld}, 64'h0);
    rst = 1'b0; in_vld = 1'b0;
    @(negedge clk);

    finish_run();
  end
endmodule